// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives the active-low system reset of a chip from two causes: a supply-good level coming from an external voltage comparator, and an active-low manual reset button. While either cause is active, the reset output stays low and the stretch counter is held at zero. Once both causes have gone away, the counter runs for a fixed number of clock cycles, and the reset is released when it reaches its end. A supply dip or a button press that lands in the middle of the count clears the counter, so every release comes after a full, uninterrupted stretch.

Each input passes through a two-flop synchronizer. The manual input's synchronizer powers up at the released (high) level, which matches an input with a pull-up when nothing drives it. A manual low is acted on only after it has been seen low for a minimum number of consecutive cycles. Shorter glitches are ignored. The stretch length and the minimum press width are parameters given in clock cycles. A single-cycle flag marks the cycle in which the reset is released, so that a downstream watchdog can start from it.

An asynchronous active-low power-on clear puts the block in its starting state: reset asserted, counter at zero.

Top module: `rst_supervisor`

## Requirements
- R1: After the power-on clear, `sys_rst_n_o` is 0 and `rst_release_o` is 0.
- R2: When `supply_ok_i` goes to 0 while reset is released, `sys_rst_n_o` goes to 0 on the 3rd rising clock edge after the change.
- R3: When `supply_ok_i` goes to 1 with the manual input released, `sys_rst_n_o` goes to 1 on the (RST_CYCLES+3)th rising edge after the change and stays 0 until then.
- R4: A supply drop in the middle of the stretch clears the counter. Release then comes a full RST_CYCLES+3 edges after the supply returns.
- R5: A manual low (`man_rst_n_i` = 0) held for at least MR_MIN_CYCLES cycles forces `sys_rst_n_o` to 0 on the (MR_MIN_CYCLES+3)th edge after the press begins.
- R6: After a recognised manual press ends (`man_rst_n_i` back to 1), `sys_rst_n_o` goes to 1 on the (RST_CYCLES+4)th edge after the release.
- R7: A manual low shorter than MR_MIN_CYCLES cycles is ignored. `sys_rst_n_o` stays 1 and `rst_release_o` stays 0. A low of exactly MR_MIN_CYCLES cycles is recognised.
- R8: `rst_release_o` is 1 for exactly the one cycle in which `sys_rst_n_o` changes from 0 to 1, and is 0 at all other times.
- R9: A recognised manual press in the middle of the stretch restarts it. Release comes RST_CYCLES+4 edges after the final manual release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok_i | input | 1 | Supply-good level from the external comparator, 1 = above threshold (asynchronous) |
| man_rst_n_i | input | 1 | Manual reset button, active low (asynchronous) |
| sys_rst_n_o | output | 1 | System reset, active low |
| rst_release_o | output | 1 | One-cycle pulse on the release of reset |

## Verification
Each result has a fixed latency, counted in rising edges from the stimulus:
- a supply drop shows at the output after 3 edges (two synchronizer flops plus the output register);
- a manual press shows after MR_MIN_CYCLES+3 edges (the qualifier adds its run count);
- a supply return releases reset after RST_CYCLES+3 edges;
- a manual release releases reset after RST_CYCLES+4 edges (the extra edge is the qualifier clearing).

The bench drives inputs on falling edges and counts falling edges until the output changes, so each count equals the number of rising edges in between. It compares that count exactly against the figure above. For the ignored-press and mid-count cases, it also watches the output on every cycle in between.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  // Bits needed to hold the values 0..n inclusive.
  function automatic int unsigned cnt_w(input int unsigned n);
    cnt_w = (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Next value of a run counter that saturates at lim and clears when run is low.
  function automatic int unsigned run_next(input int unsigned cur,
                                           input int unsigned lim,
                                           input logic run);
    if (!run)
      run_next = 0;
    else if (cur >= lim)
      run_next = lim;
    else
      run_next = cur + 1;
  endfunction

  // Edges from a supply return to reset release: two sync flops, the count, the output flop.
  function automatic int unsigned supply_release_lat(input int unsigned stretch);
    supply_release_lat = stretch + 3;
  endfunction

endpackage

// File: rtl/rstsup_sync2.sv
module rstsup_sync2 #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= INIT;
      stab_q <= INIT;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/rstsup_press_qual.sv
module rstsup_press_qual #(
  parameter int unsigned MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic btn_n_i,
  output logic press_o
);
  localparam int unsigned W = rstsup_pkg::cnt_w(MIN_CYCLES);
  localparam logic [W-1:0] LIM = W'(MIN_CYCLES);

  logic [W-1:0] run_q;
  logic [W-1:0] run_d;
  logic         is_low;

  assign is_low = ~btn_n_i;
  assign run_d  = W'(rstsup_pkg::run_next(int'(run_q), MIN_CYCLES, is_low));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign press_o = (run_q == LIM);

  // R7: a press is reported only after a run of low samples, so the sampled
  // input must still have been low one cycle earlier.
  press_needs_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(press_o) |-> $past(is_low));

  // R6: a high sample ends the press on the next cycle.
  press_ends_chk: assert property (@(posedge clk) disable iff (!por_n)
    btn_n_i |=> !press_o);
endmodule

// File: rtl/rstsup_stretch.sv
module rstsup_stretch #(
  parameter int unsigned STRETCH = 20
) (
  input  logic clk,
  input  logic por_n,
  input  logic hold_i,
  output logic done_o
);
  localparam int unsigned W = rstsup_pkg::cnt_w(STRETCH);
  localparam logic [W-1:0] FULL = W'(STRETCH);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             cnt_q <= '0;
    else if (hold_i)        cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == FULL);

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    hold_i |=> (cnt_q == '0));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!hold_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned RST_CYCLES    = 20,
  parameter int unsigned MR_MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok_i,
  input  logic man_rst_n_i,
  output logic sys_rst_n_o,
  output logic rst_release_o
);
  logic supply_s;
  logic man_s;
  logic man_press;
  logic hold_w;
  logic done_w;
  logic rst_n_q;
  logic rel_q;

  rstsup_sync2 #(.INIT(1'b0)) u_sync_sup (
    .clk(clk), .por_n(por_n), .d_i(supply_ok_i), .q_o(supply_s));

  rstsup_sync2 #(.INIT(1'b1)) u_sync_man (
    .clk(clk), .por_n(por_n), .d_i(man_rst_n_i), .q_o(man_s));

  rstsup_press_qual #(.MIN_CYCLES(MR_MIN_CYCLES)) u_qual (
    .clk(clk), .por_n(por_n), .btn_n_i(man_s), .press_o(man_press));

  assign hold_w = ~supply_s | man_press;

  rstsup_stretch #(.STRETCH(RST_CYCLES)) u_stretch (
    .clk(clk), .por_n(por_n), .hold_i(hold_w), .done_o(done_w));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_n_q <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      rst_n_q <= ~hold_w & done_w;
      rel_q   <= ~hold_w & done_w & ~rst_n_q;
    end
  end

  assign sys_rst_n_o   = rst_n_q;
  assign rst_release_o = rel_q;

  // R2
  supply_low_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    !supply_s |=> !sys_rst_n_o);

  // R5
  press_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    man_press |=> !sys_rst_n_o);

  // R3
  release_after_full_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n_o) |-> $past(done_w));

  // R8
  flag_on_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_release_o |-> $rose(sys_rst_n_o));

  // R8
  flag_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_release_o |=> !rst_release_o);
endmodule

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
  localparam int unsigned RST = 20;
  localparam int unsigned MRM = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_ok = 1'b0;
  logic man_n = 1'b1;
  logic rst_n;
  logic rel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rst_supervisor #(.RST_CYCLES(RST), .MR_MIN_CYCLES(MRM)) u0 (
    .clk(clk), .por_n(por_n), .supply_ok_i(supply_ok), .man_rst_n_i(man_n),
    .sys_rst_n_o(rst_n), .rst_release_o(rel));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count falling edges until rst_n reaches lvl (stops after lim).
  task automatic edges_until(input logic lvl, input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (rst_n !== lvl && n < lim);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 rst_n after clear", int'(rst_n), 0);
    check("R1 flag after clear", int'(rel), 0);
  endtask

  task automatic t_powerup;
    int n;
    @(negedge clk);
    supply_ok = 1'b1;
    edges_until(1'b1, 200, n);
    check("R3 release latency", n, RST + 3);
    check("R8 flag at release", int'(rel), 1);
    @(negedge clk);
    check("R8 flag one cycle", int'(rel), 0);
  endtask

  task automatic t_supply_drop;
    int n;
    supply_ok = 1'b0;
    edges_until(1'b0, 50, n);
    check("R2 drop latency", n, 3);
  endtask

  task automatic t_brownout_mid;
    int n;
    int low_seen = 1;
    supply_ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rst_n !== 1'b0) low_seen = 0;
    end
    supply_ok = 1'b0;
    idle(4);
    supply_ok = 1'b1;
    edges_until(1'b1, 200, n);
    check("R4 held low in count", low_seen, 1);
    check("R4 full restart latency", n, RST + 3);
  endtask

  task automatic t_manual_long;
    int n;
    man_n = 1'b0;
    edges_until(1'b0, 50, n);
    check("R5 press latency", n, MRM + 3);
    idle(3);
    man_n = 1'b1;
    edges_until(1'b1, 200, n);
    check("R6 release latency", n, RST + 4);
  endtask

  task automatic t_manual_short;
    int low_seen = 0;
    int flag_seen = 0;
    man_n = 1'b0;
    idle(MRM - 1);
    man_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rst_n !== 1'b1) low_seen = 1;
      if (rel !== 1'b0) flag_seen = 1;
    end
    check("R7 short press rst low", low_seen, 0);
    check("R7 short press flag", flag_seen, 0);
  endtask

  task automatic t_manual_exact;
    int n;
    int low_seen = 0;
    man_n = 1'b0;
    idle(MRM);
    man_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (rst_n === 1'b0) low_seen = 1;
    end while (!(low_seen == 1 && rst_n === 1'b1) && n < 200);
    check("R7 exact press recognised", low_seen, 1);
    check("R6 exact press release latency", n, RST + 4);
  endtask

  task automatic t_manual_mid;
    int n;
    man_n = 1'b0;
    idle(MRM + 3);
    man_n = 1'b1;
    idle(10);
    check("R9 still low mid count", int'(rst_n), 0);
    man_n = 1'b0;
    idle(MRM + 2);
    man_n = 1'b1;
    edges_until(1'b1, 200, n);
    check("R9 full restart latency", n, RST + 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    por_n = 1'b1;
    idle(2);
    t_reset();
    t_powerup();
    t_supply_drop();
    t_brownout_mid();
    t_manual_long();
    t_manual_short();
    t_manual_exact();
    t_manual_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule